// File: doc/BRIEF.md
# Sticky Floating-Point Status Register

This block is a 64-bit status register for a floating-point and SIMD unit. The arithmetic datapath sends it single-cycle event pulses: invalid operation, divide-by-zero, overflow, underflow, inexact, input denormal and integer saturation. Each pulse sets a sticky flag, and the flag stays set until software writes a zero to it.

Whether a floating-point event is recorded depends on its trap-enable input. An event is recorded only when its trap is disabled. Underflow is the exception: it is also recorded whenever flush-to-zero mode is on. Saturation has no trap enable and is always recorded.

The register can also hold four comparison flags for a legacy 32-bit mode. A compare-update input loads them, and software can write them too. When the parameter `LEGACY_CMP_EN` is 0, those bits read as zero. Software reads the register combinationally and writes the whole word in one cycle. Reserved bits read as zero.

Top module: `fpstat_reg`

## Requirements
- R1: After synchronous reset every bit of `rd_data` reads 0.
- R2: Bits 63:32, 26:8 and 6:5 always read 0, and writing ones to them has no effect.
- R3: Each `evt_pulse` bit maps to one register bit. Bit 0 (invalid) maps to bit 0, bit 1 (divide-by-zero) to bit 1, bit 2 (overflow) to bit 2, bit 3 (underflow) to bit 3, bit 4 (inexact) to bit 4, bit 5 (input denormal) to bit 7, and bit 6 (saturation) to bit 27. A pulse with its trap enable clear sets the mapped bit one clock later.
- R4: For event bits 0, 1, 2, 4 and 5, the pulse is ignored while `trap_en` has a 1 at the same index.
- R5: An underflow pulse sets bit 3 whenever `ftz_mode` is 1, whatever `trap_en[3]` holds. With `ftz_mode` at 0 and `trap_en[3]` at 1, the pulse is ignored.
- R6: A saturation pulse sets bit 27 regardless of any trap enable or mode input.
- R7: A set flag holds at 1 through idle cycles. A write with `wr_en` loads each flag from the matching `wr_data` bit, so writing 0 clears the flag.
- R8: If a write of 0 and a recorded event hit the same flag in the same cycle, the flag ends at 1.
- R9: Several pulses in one cycle are each gated by their own enable and recorded independently.
- R10: With `LEGACY_CMP_EN`=1, `cmp_upd` loads `cmp_nzcv[3:0]` into bits 31:28 (bit 3 goes to bit 31) and leaves the other bits unchanged.
- R11: With `LEGACY_CMP_EN`=1, a write loads bits 31:28 from `wr_data`. If a write and `cmp_upd` occur in the same cycle, bits 31:28 take `cmp_nzcv`.
- R12: With `LEGACY_CMP_EN`=0, bits 31:28 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 7 | Per-cycle exception and saturation event pulses |
| trap_en | input | 6 | Trap enables for event bits 0 to 5 |
| ftz_mode | input | 1 | Flush-to-zero mode |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 64 | Software write data |
| cmp_upd | input | 1 | Legacy compare result strobe |
| cmp_nzcv | input | 4 | Legacy compare flags {N,Z,C,V} |
| rd_data | output | 64 | Current register contents |

## Verification
The properties assume that the inputs change only between clock edges and hold known values once reset is released. They do not assume that the inputs are one-hot or mutually exclusive.

Because of this, the stimulus deliberately overlaps events, writes and compare updates in the same cycle to exercise the priority rules. Inputs are driven on the falling edge and cleared after a single cycle, so each pulse lasts exactly one clock. A second instance with the legacy flags disabled receives the same stimulus.

// File: rtl/fpstat_pkg.sv
package fpstat_pkg;

    localparam int REG_W    = 64;
    localparam int NUM_EVT  = 7;
    localparam int NUM_TRAP = 6;
    localparam int CMP_W    = 4;

    localparam int EV_INV = 0;
    localparam int EV_DZ  = 1;
    localparam int EV_OF  = 2;
    localparam int EV_UF  = 3;
    localparam int EV_IX  = 4;
    localparam int EV_ID  = 5;
    localparam int EV_SAT = 6;

    localparam int CMP_LO = 28;
    localparam int CMP_HI = CMP_LO + CMP_W - 1;

    // Register bit position that records each event index.
    function automatic int flag_pos(input int idx);
        case (idx)
            EV_ID:   return 7;
            EV_SAT:  return 27;
            default: return idx;
        endcase
    endfunction

    // Bits that can ever read as one.
    function automatic logic [REG_W-1:0] live_mask(input bit legacy);
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_EVT; i++) m[flag_pos(i)] = 1'b1;
        if (legacy) m[CMP_HI:CMP_LO] = '1;
        return m;
    endfunction

    typedef struct packed {
        logic [CMP_W-1:0]   nzcv;
        logic [NUM_EVT-1:0] flags;
    } fpstat_state_t;

endpackage

// File: rtl/fpstat_event_gate.sv
module fpstat_event_gate
    import fpstat_pkg::*;
#(
    parameter int N_EVT  = NUM_EVT,
    parameter int N_TRAP = NUM_TRAP,
    parameter int UF_IDX = EV_UF
) (
    input  logic [N_EVT-1:0]  evt,
    input  logic [N_TRAP-1:0] trap,
    input  logic              ftz,
    output logic [N_EVT-1:0]  set
);
    for (genvar i = 0; i < N_EVT; i++) begin : g_evt
        if (i >= N_TRAP) begin : g_untrapped
            assign set[i] = evt[i];
        end else if (i == UF_IDX) begin : g_underflow
            assign set[i] = evt[i] & (~trap[i] | ftz);
        end else begin : g_trapped
            assign set[i] = evt[i] & ~trap[i];
        end
    end
endmodule

// File: rtl/fpstat_sticky_bank.sv
module fpstat_sticky_bank #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [N-1:0] wr_val,
    input  logic [N-1:0] set,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic nxt;
        // Hardware set is ORed after the write so it wins a collision.
        assign nxt = (wr_en ? wr_val[i] : q[i]) | set[i];
        always_ff @(posedge clk) begin
            if (rst) q[i] <= 1'b0;
            else     q[i] <= nxt;
        end
    end
endmodule

// File: rtl/fpstat_cond_flags.sv
module fpstat_cond_flags #(
    parameter bit LEGACY = 1'b1,
    parameter int W      = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic         cmp_upd,
    input  logic [W-1:0] cmp_val,
    output logic [W-1:0] q
);
    if (LEGACY) begin : g_on
        always_ff @(posedge clk) begin
            if (rst)          q <= '0;
            else if (cmp_upd) q <= cmp_val;
            else if (wr_en)   q <= wr_val;
        end
    end else begin : g_off
        logic unused_inputs;
        assign unused_inputs = ^{clk, rst, wr_en, wr_val, cmp_upd, cmp_val};
        assign q = '0;
    end
endmodule

// File: rtl/fpstat_reg.sv
module fpstat_reg
    import fpstat_pkg::*;
#(
    parameter bit LEGACY_CMP_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_EVT-1:0]  evt_pulse,
    input  logic [NUM_TRAP-1:0] trap_en,
    input  logic              ftz_mode,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              cmp_upd,
    input  logic [CMP_W-1:0]  cmp_nzcv,
    output logic [REG_W-1:0]  rd_data
);
    fpstat_state_t      st;
    logic [NUM_EVT-1:0] set_q;
    logic [NUM_EVT-1:0] wr_flags;

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_wr
        assign wr_flags[i] = wr_data[flag_pos(i)];
    end

    logic unused_rsv;
    assign unused_rsv = ^{wr_data[REG_W-1:32], wr_data[26:8], wr_data[6:5]};

    fpstat_event_gate #(.N_EVT(NUM_EVT), .N_TRAP(NUM_TRAP), .UF_IDX(EV_UF)) u_gate (
        .evt  (evt_pulse),
        .trap (trap_en),
        .ftz  (ftz_mode),
        .set  (set_q)
    );

    fpstat_sticky_bank #(.N(NUM_EVT)) u_sticky (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_val (wr_flags),
        .set    (set_q),
        .q      (st.flags)
    );

    fpstat_cond_flags #(.LEGACY(LEGACY_CMP_EN), .W(CMP_W)) u_cond (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_val  (wr_data[CMP_HI:CMP_LO]),
        .cmp_upd (cmp_upd),
        .cmp_val (cmp_nzcv),
        .q       (st.nzcv)
    );

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_EVT; i++) rd_data[flag_pos(i)] = st.flags[i];
        rd_data[CMP_HI:CMP_LO] = st.nzcv;
    end
endmodule

// File: rtl/fpstat_reg_chk.sv
module fpstat_reg_chk
    import fpstat_pkg::*;
#(
    parameter bit LEGACY_CMP_EN = 1'b1
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_EVT-1:0]  evt_pulse,
    input logic [NUM_TRAP-1:0] trap_en,
    input logic                ftz_mode,
    input logic                wr_en,
    input logic [REG_W-1:0]    wr_data,
    input logic                cmp_upd,
    input logic [CMP_W-1:0]    cmp_nzcv,
    input logic [REG_W-1:0]    rd_data
);
    localparam logic [REG_W-1:0] RSV = ~live_mask(1'b1);

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_data & RSV) == '0);

    for (genvar i = 0; i < NUM_TRAP; i++) begin : g_trap
        if (i != EV_UF) begin : g_plain
            assert_trap_blocks_R4: assert property (@(posedge clk) disable iff (rst)
                (!wr_en && evt_pulse[i] && trap_en[i] && !rd_data[flag_pos(i)])
                |=> !rd_data[flag_pos(i)]);
        end
    end

    assert_ftz_underflow_R5: assert property (@(posedge clk) disable iff (rst)
        (evt_pulse[EV_UF] && ftz_mode) |=> rd_data[flag_pos(EV_UF)]);

    assert_sat_always_R6: assert property (@(posedge clk) disable iff (rst)
        evt_pulse[EV_SAT] |=> rd_data[flag_pos(EV_SAT)]);

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_hold
        assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (rst)
            (!wr_en && rd_data[flag_pos(i)]) |=> rd_data[flag_pos(i)]);
    end

    assert_hw_beats_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[flag_pos(EV_INV)] && evt_pulse[EV_INV] && !trap_en[EV_INV])
        |=> rd_data[flag_pos(EV_INV)]);

    if (LEGACY_CMP_EN) begin : g_leg
        assert_cmp_load_R10: assert property (@(posedge clk) disable iff (rst)
            cmp_upd |=> rd_data[CMP_HI:CMP_LO] == $past(cmp_nzcv));
    end else begin : g_noleg
        assert_cmp_zero_R12: assert property (@(posedge clk) disable iff (rst)
            rd_data[CMP_HI:CMP_LO] == '0);
    end
endmodule

bind fpstat_reg fpstat_reg_chk #(.LEGACY_CMP_EN(LEGACY_CMP_EN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .evt_pulse (evt_pulse),
    .trap_en   (trap_en),
    .ftz_mode  (ftz_mode),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .cmp_upd   (cmp_upd),
    .cmp_nzcv  (cmp_nzcv),
    .rd_data   (rd_data)
);

// File: tb/tb_fpstat_reg.sv
module tb_fpstat_reg;
    logic        clk = 1'b0;
    logic        rst;
    logic [6:0]  evt_pulse;
    logic [5:0]  trap_en;
    logic        ftz_mode;
    logic        wr_en;
    logic [63:0] wr_data;
    logic        cmp_upd;
    logic [3:0]  cmp_nzcv;
    logic [63:0] rd_data;
    logic [63:0] rd_nl;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    localparam int POS [7] = '{0, 1, 2, 3, 4, 7, 27};

    always #5 clk = ~clk;

    fpstat_reg #(.LEGACY_CMP_EN(1'b1)) dut (
        .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .trap_en(trap_en),
        .ftz_mode(ftz_mode), .wr_en(wr_en), .wr_data(wr_data),
        .cmp_upd(cmp_upd), .cmp_nzcv(cmp_nzcv), .rd_data(rd_data));

    fpstat_reg #(.LEGACY_CMP_EN(1'b0)) dut_nl (
        .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .trap_en(trap_en),
        .ftz_mode(ftz_mode), .wr_en(wr_en), .wr_data(wr_data),
        .cmp_upd(cmp_upd), .cmp_nzcv(cmp_nzcv), .rd_data(rd_nl));

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        evt_pulse = '0; trap_en = '0; ftz_mode = 1'b0;
        wr_en = 1'b0; wr_data = '0; cmp_upd = 1'b0; cmp_nzcv = '0;
    endtask

    // Inputs are applied at a falling edge; one rising edge later the result is read.
    task automatic tick();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic clear_all();
        wr_en = 1'b1; wr_data = '0;
        tick();
    endtask

    task automatic pulse(input logic [6:0] e, input logic [5:0] t, input logic f);
        evt_pulse = e; trap_en = t; ftz_mode = f;
        tick();
    endtask

    task automatic t_reset();
        check("R1 reset", rd_data, 64'h0);
        check("R1 reset legacy-off", rd_nl, 64'h0);
    endtask

    task automatic t_record();
        for (int i = 0; i < 7; i++) begin
            clear_all();
            pulse(7'(1 << i), 6'h00, 1'b0);
            check($sformatf("R3 event %0d", i), rd_data, 64'(1) << POS[i]);
        end
    endtask

    task automatic t_trap();
        int idx [5] = '{0, 1, 2, 4, 5};
        for (int k = 0; k < 5; k++) begin
            clear_all();
            pulse(7'(1 << idx[k]), 6'h3f, 1'b0);
            check($sformatf("R4 trapped event %0d", idx[k]), rd_data, 64'h0);
        end
    endtask

    task automatic t_ftz();
        clear_all();
        pulse(7'h08, 6'h3f, 1'b0);
        check("R5 underflow trapped no ftz", rd_data, 64'h0);
        pulse(7'h08, 6'h3f, 1'b1);
        check("R5 underflow with ftz", rd_data, 64'h8);
    endtask

    task automatic t_sat();
        clear_all();
        pulse(7'h40, 6'h3f, 1'b1);
        check("R6 saturation", rd_data, 64'h0800_0000);
    endtask

    task automatic t_sticky();
        clear_all();
        pulse(7'h01, 6'h00, 1'b0);
        tick(); tick(); tick();
        check("R7 hold through idle", rd_data, 64'h1);
        wr_en = 1'b1; wr_data = 64'h4;
        tick();
        check("R7 write clears and loads", rd_data, 64'h4);
    endtask

    task automatic t_collide();
        clear_all();
        wr_en = 1'b1; wr_data = '0; evt_pulse = 7'h01;
        tick();
        check("R8 set beats clear", rd_data, 64'h1);
        wr_en = 1'b1; wr_data = '0; evt_pulse = 7'h02; trap_en = 6'h02;
        tick();
        check("R8 trapped event loses to clear", rd_data, 64'h0);
    endtask

    task automatic t_multi();
        clear_all();
        pulse(7'h7f, 6'h00, 1'b0);
        check("R9 all events", rd_data, 64'h0800_009F);
        clear_all();
        pulse(7'h14, 6'h04, 1'b0);
        check("R9 mixed enables", rd_data, 64'h10);
    endtask

    task automatic t_reserved();
        wr_en = 1'b1; wr_data = '1;
        tick();
        check("R2 write all ones", rd_data, 64'hF800_009F);
        check("R2 write all ones legacy-off", rd_nl, 64'h0800_009F);
    endtask

    task automatic t_cmp();
        clear_all();
        pulse(7'h01, 6'h00, 1'b0);
        cmp_upd = 1'b1; cmp_nzcv = 4'hA;
        tick();
        check("R10 compare load", rd_data, 64'hA000_0001);
        check("R12 legacy-off compare", rd_nl, 64'h1);
        wr_en = 1'b1; wr_data = 64'h5000_0000;
        tick();
        check("R11 software write", rd_data, 64'h5000_0000);
        wr_en = 1'b1; wr_data = 64'h5000_0000; cmp_upd = 1'b1; cmp_nzcv = 4'h3;
        tick();
        check("R11 compare beats write", rd_data, 64'h3000_0000);
        check("R12 legacy-off reads zero", rd_nl, 64'h0);
    endtask

    initial begin
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_record();
        t_trap();
        t_ftz();
        t_sat();
        t_sticky();
        t_collide();
        t_multi();
        t_reserved();
        t_cmp();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule